// File: doc/BRIEF.md
# Compare/Capture Timer Channel

This block is a single timer channel driven by a free-running up-counter. A small prescaler divides the system clock by a programmable ratio, and the counter advances once on each prescaler tick. In compare mode, two compare values are checked against the counter on tick cycles. A hit on either one sets or clears an output flip-flop, and a polarity bit chooses which comparator does which. In capture mode, the counter is sampled into a capture register when the capture input shows the chosen edge, and a sticky flag is raised.

A gate sits between the flip-flop and the output pin. Any one of four shared disable lines can be chosen as the source of the gate. When the gate is enabled and the chosen line is high, the pin is forced to its inactive level. This lets a system-level fault signal stop several channels at once.

Top module: `tmr_chan`

## Requirements
- R1: With polarity 0 in compare mode, a tick on which the counter equals compare A clears the output flip-flop, and a tick on which it equals compare B sets it. The new level shows on the pin one clock after that tick.
- R2: With polarity 1 in compare mode, a compare A hit sets the flip-flop and a compare B hit clears it.
- R3: When A and B hit on the same tick, the B action is taken.
- R4: A prescaler field value n (0 to 3) makes a tick every n+1 clock cycles. The counter increments by one, wrapping, only on tick cycles, and comparisons are made only on tick cycles.
- R5: In capture mode, a capture edge copies the counter value of that cycle into the capture register and sets the flag one clock later. Polarity 1 selects the rising edge (capture input was 0 on the previous clock and is 1 now). Polarity 0 selects the falling edge.
- R6: A flag-clear strobe clears the flag on the next clock. If a capture edge happens in the same cycle, the flag stays set.
- R7: The disable select value k picks disable input k. While the gate enable is 1 and that input is 1, the pin equals the polarity bit, which is the level a compare A hit drives. The other disable inputs have no effect.
- R8: Synchronous reset zeroes the counter, the prescaler, the capture register and the flag, and loads the flip-flop with the polarity bit.
- R9: In capture mode, compare hits leave the flip-flop unchanged. In compare mode, capture edges leave the flag and the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_sel | input | PRE_W | Prescaler field, divide ratio is value+1 |
| pol | input | 1 | Polarity: output action swap and capture edge |
| cap_mode | input | 1 | 0 compare mode, 1 capture mode |
| cmp_a | input | CNT_W | Compare A value |
| cmp_b | input | CNT_W | Compare B value |
| cap_in | input | 1 | Capture input |
| dis_in | input | DIS_N | Shared disable lines |
| dis_sel | input | SEL_W | Selects one disable line |
| dis_en | input | 1 | Enables the disable gate |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| out_pin | output | 1 | Gated output flip-flop level |
| cap_val | output | CNT_W | Capture register |
| flag | output | 1 | Capture event flag |

## Verification
The hardest case to reach from the ports is a capture edge and a flag-clear strobe landing in the same clock cycle while the prescaler ratio is above one. To produce it, the stimulus raises the capture input and the clear strobe on the same falling clock edge. A coincident A/B hit is also hard to reach, because it only happens on a tick where the counter passes a shared compare value. To make it happen, equal compare values are left in place over several counter wraps under both polarities. A cycle-level reference model predicts the flip-flop, flag and capture register every clock, so each of these coincidences is compared on the exact cycle where it occurs.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        FF_HOLD = 2'd0,
        FF_SET  = 2'd1,
        FF_CLR  = 2'd2
    } ff_act_e;

    typedef struct packed {
        logic hit_a;
        logic hit_b;
    } cmp_hit_t;

    // B wins over A; polarity swaps set/clear roles
    function automatic ff_act_e pick_act(cmp_hit_t h, logic p);
        if (h.hit_b) return p ? FF_CLR : FF_SET;
        if (h.hit_a) return p ? FF_SET : FF_CLR;
        return FF_HOLD;
    endfunction

    function automatic logic edge_seen(logic now_v, logic prev_v, logic p);
        return p ? (now_v & ~prev_v) : (~now_v & prev_v);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;

    assign tick = (div_q >= div_sel);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> div_q == $past(div_q) + 1'b1);

endmodule

// File: rtl/tmr_count_cmp.sv
module tmr_count_cmp
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cnt,
    output cmp_hit_t         hit
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    always_comb begin
        hit.hit_a = cmp_en && tick && (cnt == cmp_a);
        hit.hit_b = cmp_en && tick && (cnt == cmp_b);
    end

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/tmr_outff.sv
module tmr_outff
    import tmr_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pol,
    input  cmp_hit_t hit,
    output logic     ff_q
);
    ff_act_e act;

    assign act = pick_act(hit, pol);

    always_ff @(posedge clk) begin
        if (rst) ff_q <= pol;
        else begin
            case (act)
                FF_SET:  ff_q <= 1'b1;
                FF_CLR:  ff_q <= 1'b0;
                default: ff_q <= ff_q;
            endcase
        end
    end

    // R3
    b_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit.hit_b |=> ff_q == !$past(pol));

    // R1
    a_only_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.hit_a && !hit.hit_b) |=> ff_q == $past(pol));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             pol,
    input  logic             cap_in,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag
);
    logic prev_q;
    logic hit_edge;

    assign hit_edge = cap_en && edge_seen(cap_in, prev_q, pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            cap_val <= '0;
            flag    <= 1'b0;
        end else begin
            prev_q <= cap_in;
            if (hit_edge) begin
                cap_val <= cnt;
                flag    <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    // R5
    cap_latch_chk: assert property (@(posedge clk) disable iff (rst)
        hit_edge |=> flag && cap_val == $past(cnt));

    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit_edge) |=> !flag);

    // R9
    cap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(cap_val));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 2,
    parameter int DIS_N = 4,
    localparam int SEL_W = $clog2(DIS_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             pol,
    input  logic             cap_mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             cap_in,
    input  logic [DIS_N-1:0] dis_in,
    input  logic [SEL_W-1:0] dis_sel,
    input  logic             dis_en,
    input  logic             flag_clr,
    output logic             out_pin,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    cmp_hit_t         hit;
    logic             ff_q;
    logic             gate_on;

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .div_sel(pre_sel), .tick(tick)
    );

    tmr_count_cmp #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cmp_en(!cap_mode),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt(cnt), .hit(hit)
    );

    tmr_outff u_ff (
        .clk(clk), .rst(rst), .pol(pol), .hit(hit), .ff_q(ff_q)
    );

    tmr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .cap_en(cap_mode), .pol(pol), .cap_in(cap_in),
        .clr(flag_clr), .cnt(cnt), .cap_val(cap_val), .flag(flag)
    );

    assign gate_on = dis_en && dis_in[dis_sel];
    assign out_pin = gate_on ? pol : ff_q;

    // R9
    ff_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cap_mode |=> $stable(ff_q));

endmodule

// File: tb/tmr_chan_bench.sv
`timescale 1ns/1ps
module tmr_chan_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   pre_sel = 2'd0;
    logic         pol = 1'b0;
    logic         cap_mode = 1'b0;
    logic [W-1:0] cmp_a = '0;
    logic [W-1:0] cmp_b = '0;
    logic         cap_in = 1'b0;
    logic [3:0]   dis_in = 4'd0;
    logic [1:0]   dis_sel = 2'd0;
    logic         dis_en = 1'b0;
    logic         flag_clr = 1'b0;
    logic         out_pin;
    logic [W-1:0] cap_val;
    logic         flag;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic         ff;
        logic         flg;
        logic [W-1:0] cap;
        string        req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tmr_chan #(.CNT_W(W)) u_tmr_chan (
        .clk(clk), .rst(rst), .pre_sel(pre_sel), .pol(pol), .cap_mode(cap_mode),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cap_in(cap_in), .dis_in(dis_in),
        .dis_sel(dis_sel), .dis_en(dis_en), .flag_clr(flag_clr),
        .out_pin(out_pin), .cap_val(cap_val), .flag(flag)
    );

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: pushes the expected state after every clock edge
    logic [1:0]   m_pre;
    logic [W-1:0] m_cnt, m_cap;
    logic         m_ff, m_flag, m_prev;
    always @(posedge clk) begin
        exp_t e;
        logic tk, ra, rb, red, ha, hb, ed;
        if (rst) begin
            m_pre = '0; m_cnt = '0; m_cap = '0;
            m_ff = pol; m_flag = 1'b0; m_prev = 1'b0;
            e.req = "R8";
        end else begin
            tk  = (m_pre >= pre_sel);
            ra  = tk && (m_cnt == cmp_a);
            rb  = tk && (m_cnt == cmp_b);
            red = pol ? (cap_in && !m_prev) : (!cap_in && m_prev);
            ha  = !cap_mode && ra;
            hb  = !cap_mode && rb;
            ed  = cap_mode && red;
            if (cap_mode)
                e.req = (ed && flag_clr) ? "R6" : ed ? "R5" : (ra || rb) ? "R9" :
                        flag_clr ? "R6" : "R5";
            else
                e.req = (ha && hb) ? "R3" : (ha || hb) ? (pol ? "R2" : "R1") :
                        red ? "R9" : (pre_sel != 0) ? "R4" : "R1";
            if (hb)      m_ff = !pol;
            else if (ha) m_ff = pol;
            if (ed) begin
                m_cap  = m_cnt;
                m_flag = 1'b1;
            end else if (flag_clr) begin
                m_flag = 1'b0;
            end
            m_prev = cap_in;
            m_pre  = tk ? 2'd0 : m_pre + 2'd1;
            if (tk) m_cnt = m_cnt + 1'b1;
        end
        e.ff = m_ff; e.flg = m_flag; e.cap = m_cap;
        exp_q.push_back(e);
    end

    // monitor: compares one expected item per clock, away from the edge
    always begin
        exp_t e;
        logic gate;
        string tag;
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            gate = dis_en && dis_in[dis_sel];
            tag = gate ? "R7" : e.req;
            chk(tag, "out_pin", W'(out_pin), W'(gate ? pol : e.ff));
            chk(e.req, "flag", W'(flag), W'(e.flg));
            chk(e.req, "cap_val", cap_val, e.cap);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        run(3);
        rst = 1'b0;
    endtask

    task automatic cap_bursts(int base);
        for (int i = 0; i < 12; i++) begin
            run(base + i);
            cap_in = !cap_in;
            run(3);
            if (i % 4 == 1) flag_clr = 1'b1;   // R6 clear strobe coincident with edge
            cap_in = !cap_in;
            run(1);
            flag_clr = 1'b0;
            run(2);
            if (i % 3 == 0) begin
                flag_clr = 1'b1;               // R6 plain clear
                run(1);
                flag_clr = 1'b0;
            end
        end
    endtask

    initial begin
        // R8 reset state, R1 polarity 0 compare
        pol = 1'b0; cmp_a = 8'd10; cmp_b = 8'd40;
        do_reset();
        run(600);
        // R2 polarity 1 with R4 prescaler ratio 3
        pol = 1'b1; pre_sel = 2'd2;
        do_reset();
        run(900);
        // R3 coincident hits, both polarities
        cmp_a = 8'd30; cmp_b = 8'd30; pre_sel = 2'd0; pol = 1'b0;
        do_reset();
        run(300);
        pol = 1'b1;
        do_reset();
        run(300);
        // R7 disable gate across every select value
        pol = 1'b0; cmp_a = 8'd10; cmp_b = 8'd40; pre_sel = 2'd1;
        do_reset();
        for (int s = 0; s < 4; s++) begin
            dis_sel = 2'(s);
            for (int v = 0; v < 16; v++) begin
                dis_in = 4'(v);
                dis_en = v[0] ^ v[2];
                run(9);
            end
        end
        dis_en = 1'b0; dis_in = 4'd0;
        // R9 capture edges in compare mode
        cap_bursts(4);
        // R5 capture mode, rising edge, prescaler ratio 2
        cap_mode = 1'b1; pol = 1'b1; pre_sel = 2'd1; cap_in = 1'b0;
        do_reset();
        cap_bursts(5);
        // R5 capture mode, falling edge, prescaler ratio 4
        pol = 1'b0; pre_sel = 2'd3; cap_in = 1'b1;
        do_reset();
        cap_bursts(6);
        // R6 edge and clear in the same cycle, explicit
        pol = 1'b1; cap_in = 1'b0;
        run(2);
        cap_in = 1'b1; flag_clr = 1'b1;
        run(1);
        flag_clr = 1'b0;
        run(3);
        run(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule